// File: doc/BRIEF.md
# Ambient Backlight Level Selector with Fade

This block produces the 7-bit current code for one group of backlight LEDs. Software programs a small register set: a brightness pair (full and dimmed) for each of three light levels (daylight, office, dark), a manual level field, an ambient-automatic enable, two fade durations and a fade law. In automatic mode, two ambient comparator flags pick the level instead of the manual field. A dim request picks the dimmed value of the active level.

When the selected target differs from the present code, the block sweeps the code toward it. The sweep is paced by a millisecond tick, and its shape is linear, square or cubic. An override bit makes the code jump to the target at once. A new target that arrives during a sweep restarts the sweep from the code reached so far.

The controller has two states. `ST_IDLE` holds the code. `ST_FADE` advances one step per tick. The transitions are:
- start (`ST_IDLE` to `ST_FADE`, when the target differs and override is clear)
- restart (`ST_FADE` to `ST_FADE`, when the target moves)
- finish (`ST_FADE` to `ST_IDLE`, after the last tick)
- snap (override, which writes the target and goes to or stays in `ST_IDLE`)

Top module: `bl_level_fader`

## Requirements
- R1: After reset these values hold: current code 0, manual level daylight, automatic mode off, all six brightness registers 0, linear law, both duration indices 0, override off.
- R2: Writes use these addresses:
  - 0x01 bit0: automatic enable.
  - 0x04 bits[1:0]: manual level.
  - 0x05: fade-up index in bits[3:0], fade-down index in bits[7:4].
  - 0x06: law in bits[1:0] (00 linear, 01 square, 10 cubic, 11 linear); override in bit2.
  - Brightness, full/dim: 0x09/0x0A daylight, 0x0B/0x0C office, 0x0D/0x0E dark.
  - Bit7 of a brightness write is ignored.
- R3: Manual level codes are 00 daylight, 01 office and 10 dark. Code 11 selects dark.
- R4: With automatic mode on, the level comes from the ambient flags and the manual field has no effect. `amb_bright`=1 selects daylight. Otherwise `amb_dusk`=1 selects office. Otherwise the level is dark.
- R5: The target is the dim register of the active level while `dim_req`=1, and its full register otherwise.
- R6: With override set, the code equals a changed target on the clock edge after the target changes.
- R7: A fade latches on the edge after the target changes. Each later edge with `ms_tick`=1 advances a step count k. After T = 100 + 360·n ticks the code equals the target. n is the fade-up index when the target is above the code, and the fade-down index otherwise.
- R8: For the linear law, the code during a fade is S ± floor(|E−S|·p/1024), where p = floor(k·1024/T), S is the start code and E is the target.
- R9: For the square law the shaping value is floor(p²/1024). For the cubic law it is floor(p³/2²⁰). The code is S ± floor(|E−S|·shape/1024).
- R10: If the target changes during a fade, the next edge restarts the fade with S equal to the present code, k = 0 and T chosen from the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| amb_bright | input | 1 | Ambient above upper threshold |
| amb_dusk | input | 1 | Ambient above lower threshold |
| dim_req | input | 1 | Select dimmed brightness |
| ms_tick | input | 1 | Fade pacing tick |
| led_code | output | 7 | LED current code |

## Verification
A wrong level decode or register lookup shows at `led_code` one edge after the cause when override is set, so the level and lookup tests run with override on. A state or step counter that is off by one shows as a wrong code at a precise tick count, so fades are sampled at mid-points and at the final step and the step before it. A lost restart shows within a few ticks as a code that keeps moving toward the stale target.

// File: rtl/bl_pkg.sv
package bl_pkg;
    typedef enum logic [1:0] {LAW_LIN = 2'b00, LAW_SQR = 2'b01, LAW_CUB = 2'b10, LAW_RSV = 2'b11} bl_law_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_FADE = 1'b1} bl_state_e;

    localparam logic [7:0] A_AUTO   = 8'h01;
    localparam logic [7:0] A_LEVEL  = 8'h04;
    localparam logic [7:0] A_DUR    = 8'h05;
    localparam logic [7:0] A_SHAPE  = 8'h06;
    localparam logic [7:0] A_BRIGHT = 8'h09;
    localparam int         N_BRIGHT = 6;
endpackage

// File: rtl/bl_level_regs.sv
module bl_level_regs
    import bl_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              amb_bright,
    input  logic              amb_dusk,
    input  logic              dim_req,
    output logic [CODE_W-1:0] tgt,
    output logic [3:0]        up_sel,
    output logic [3:0]        down_sel,
    output bl_law_e           law,
    output logic              ovr
);
    logic [CODE_W-1:0] bright_q [N_BRIGHT];
    logic              auto_q;
    logic [1:0]        man_q;
    logic [1:0]        raw_lvl;
    logic [1:0]        eff_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q   <= 1'b0;
            man_q    <= 2'b00;
            up_sel   <= 4'd0;
            down_sel <= 4'd0;
            law      <= LAW_LIN;
            ovr      <= 1'b0;
            for (int i = 0; i < N_BRIGHT; i++) bright_q[i] <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_AUTO:  auto_q <= wr_data[0];
                A_LEVEL: man_q  <= wr_data[1:0];
                A_DUR: begin
                    up_sel   <= wr_data[3:0];
                    down_sel <= wr_data[7:4];
                end
                A_SHAPE: begin
                    law <= bl_law_e'(wr_data[1:0]);
                    ovr <= wr_data[2];
                end
                default: begin
                    for (int i = 0; i < N_BRIGHT; i++)
                        if (wr_addr == A_BRIGHT + 8'(i)) bright_q[i] <= wr_data[CODE_W-1:0];
                end
            endcase
        end
    end

    always_comb begin
        if (auto_q) raw_lvl = amb_bright ? 2'b00 : (amb_dusk ? 2'b01 : 2'b10);
        else        raw_lvl = man_q;
        eff_lvl = (raw_lvl == 2'b11) ? 2'b10 : raw_lvl;
        tgt     = bright_q[{eff_lvl, dim_req}];
    end

    // R2
    max_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_BRIGHT && !auto_q && man_q == 2'b00)
        |=> (dim_req || tgt == $past(wr_data[CODE_W-1:0])));
endmodule

// File: rtl/bl_fade_curve.sv
module bl_fade_curve
    import bl_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int EL_W   = 13,
    parameter int FRAC_W = 10
) (
    input  logic [CODE_W-1:0] start_code,
    input  logic [CODE_W-1:0] end_code,
    input  logic [EL_W-1:0]   k,
    input  logic [EL_W-1:0]   total,
    input  bl_law_e           law,
    output logic [CODE_W-1:0] code
);
    localparam int PW = FRAC_W + 1;
    localparam int NW = EL_W + FRAC_W;
    localparam int SW = 3 * PW + CODE_W;
    localparam logic [NW-1:0] ONE = NW'(1) << FRAC_W;

    logic [NW-1:0]     num, den, quo;
    logic [SW-1:0]     p, shape, prod;
    logic [CODE_W-1:0] mag, step;
    logic              up;

    always_comb begin
        num   = {k, {FRAC_W{1'b0}}};
        den   = NW'(total);
        quo   = num / den;
        p     = (quo > ONE) ? SW'(ONE) : SW'(quo);
        unique case (law)
            LAW_SQR: shape = (p * p) >> FRAC_W;
            LAW_CUB: shape = (p * p * p) >> (2 * FRAC_W);
            default: shape = p;
        endcase
        up    = end_code >= start_code;
        mag   = up ? end_code - start_code : start_code - end_code;
        prod  = (SW'(mag) * shape) >> FRAC_W;
        step  = (prod > SW'(mag)) ? mag : prod[CODE_W-1:0];
        code  = up ? start_code + step : start_code - step;
    end
endmodule

// File: rtl/bl_fade_fsm.sv
module bl_fade_fsm
    import bl_pkg::*;
#(
    parameter int CODE_W   = 7,
    parameter int FRAC_W   = 10,
    parameter int DUR_BASE = 100,
    parameter int DUR_STEP = 360
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] tgt,
    input  logic [3:0]        up_sel,
    input  logic [3:0]        down_sel,
    input  bl_law_e           law,
    input  logic              ovr,
    output logic [CODE_W-1:0] code_q
);
    localparam int DUR_MAX = DUR_BASE + 15 * DUR_STEP;
    localparam int EL_W    = $clog2(DUR_MAX + 1);

    bl_state_e         st_q, st_d;
    logic [CODE_W-1:0] start_q, end_q, curve_code;
    logic [EL_W-1:0]   el_q, total_q, nxt_el, new_total;

    function automatic logic [EL_W-1:0] dur_of(input logic [3:0] s);
        return EL_W'(DUR_BASE) + EL_W'(DUR_STEP) * EL_W'(s);
    endfunction

    assign nxt_el    = el_q + 1'b1;
    assign new_total = dur_of((tgt > code_q) ? up_sel : down_sel);

    bl_fade_curve #(.CODE_W(CODE_W), .EL_W(EL_W), .FRAC_W(FRAC_W)) u_curve (
        .start_code (start_q),
        .end_code   (end_q),
        .k          (nxt_el),
        .total      (total_q),
        .law        (law),
        .code       (curve_code)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (tgt != code_q && !ovr) st_d = ST_FADE;
            ST_FADE: begin
                if (ovr)                              st_d = ST_IDLE;
                else if (tgt != end_q)                st_d = ST_FADE;
                else if (tick && nxt_el >= total_q)   st_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            start_q <= '0;
            end_q   <= '0;
            el_q    <= '0;
            total_q <= EL_W'(DUR_BASE);
        end else if (ovr) begin
            code_q <= tgt;
            end_q  <= tgt;
        end else if ((st_q == ST_IDLE && tgt != code_q) || (st_q == ST_FADE && tgt != end_q)) begin
            start_q <= code_q;
            end_q   <= tgt;
            el_q    <= '0;
            total_q <= new_total;
        end else if (st_q == ST_FADE && tick) begin
            el_q   <= nxt_el;
            code_q <= (nxt_el >= total_q) ? end_q : curve_code;
        end
    end

    // R6
    override_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && tgt != code_q) |=> (code_q == $past(tgt)));

    // R8
    fade_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FADE) |-> ((start_q <= end_q) ? (code_q >= start_q && code_q <= end_q)
                                                 : (code_q <= start_q && code_q >= end_q)));

    // R7
    fade_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FADE && tgt == end_q && !ovr)
        |=> ($past(end_q >= start_q) ? (code_q >= $past(code_q)) : (code_q <= $past(code_q))));

    // R10
    restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FADE && tgt != end_q && !ovr) |=> (start_q == $past(code_q) && $stable(code_q)));
endmodule

// File: rtl/bl_level_fader.sv
module bl_level_fader
    import bl_pkg::*;
#(
    parameter int CODE_W   = 7,
    parameter int FRAC_W   = 10,
    parameter int DUR_BASE = 100,
    parameter int DUR_STEP = 360
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              amb_bright,
    input  logic              amb_dusk,
    input  logic              dim_req,
    input  logic              ms_tick,
    output logic [CODE_W-1:0] led_code
);
    logic [CODE_W-1:0] tgt;
    logic [3:0]        up_sel, down_sel;
    bl_law_e           law;
    logic              ovr;

    bl_level_regs #(.CODE_W(CODE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .amb_bright (amb_bright),
        .amb_dusk   (amb_dusk),
        .dim_req    (dim_req),
        .tgt        (tgt),
        .up_sel     (up_sel),
        .down_sel   (down_sel),
        .law        (law),
        .ovr        (ovr)
    );

    bl_fade_fsm #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .DUR_BASE(DUR_BASE), .DUR_STEP(DUR_STEP)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ms_tick),
        .tgt      (tgt),
        .up_sel   (up_sel),
        .down_sel (down_sel),
        .law      (law),
        .ovr      (ovr),
        .code_q   (led_code)
    );
endmodule

// File: tb/bl_level_fader_bench.sv
module bl_level_fader_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       amb_bright = 1'b0;
    logic       amb_dusk = 1'b0;
    logic       dim_req = 1'b0;
    logic       ms_tick = 1'b1;
    logic [6:0] led_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bl_level_fader u_bl_level_fader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .amb_bright(amb_bright), .amb_dusk(amb_dusk), .dim_req(dim_req),
        .ms_tick(ms_tick), .led_code(led_code)
    );

    task automatic chk(input string req, input int exp);
        n_chk++;
        if (int'(led_code) != exp) begin
            n_bad++;
            $display("FAIL %s: led_code=%0d expected %0d", req, led_code, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        wait_n(3);
        chk("R1 reset code", 0);
    endtask

    task automatic t_linear_up;
        wr(8'h09, 8'd100);
        wait_n(26);  chk("R8 linear k=25", 25);
        wait_n(75);  chk("R7 linear done T=100", 100);
        wait_n(5);   chk("R7 hold after fade", 100);
    endtask

    task automatic t_square_down;
        wr(8'h06, 8'h01);
        wr(8'h05, 8'h10);
        wr(8'h09, 8'd36);
        wait_n(231); chk("R9 square k=230", 84);
        wait_n(229); chk("R7 square k=459", 37);
        wait_n(1);   chk("R7 fade-down T=460 done", 36);
    endtask

    task automatic t_cubic_up;
        wr(8'h06, 8'h02);
        wr(8'h09, 8'd100);
        wait_n(51);  chk("R9 cubic k=50", 44);
        wait_n(50);  chk("R7 cubic done", 100);
    endtask

    task automatic t_override_dim;
        wr(8'h06, 8'h04);
        wr(8'h0A, 8'd20);
        wait_n(1);   chk("R5 dim reg unused without dim_req", 100);
        dim_req = 1'b1;
        wait_n(1);   chk("R6 R5 override to dim", 20);
        dim_req = 1'b0;
        wait_n(1);   chk("R5 back to full", 100);
        wr(8'h09, 8'hC8);
        wait_n(1);   chk("R2 bit7 ignored", 72);
        wr(8'h09, 8'd100);
        wait_n(1);   chk("R6 override jump", 100);
    endtask

    task automatic t_manual_levels;
        wr(8'h0B, 8'd70);
        wr(8'h0C, 8'd10);
        wr(8'h0D, 8'd50);
        wr(8'h0E, 8'd5);
        wait_n(1);   chk("R3 daylight unaffected", 100);
        wr(8'h04, 8'h01);
        wait_n(1);   chk("R3 office full", 70);
        wr(8'h04, 8'h02);
        wait_n(1);   chk("R3 dark full", 50);
        wr(8'h04, 8'h03);
        wait_n(1);   chk("R3 code 11 is dark", 50);
        dim_req = 1'b1;
        wait_n(1);   chk("R3 code 11 dark dim", 5);
        dim_req = 1'b0;
        wait_n(1);
    endtask

    task automatic t_auto;
        wr(8'h04, 8'h01);
        wait_n(1);   chk("R3 office again", 70);
        amb_bright = 1'b1;
        wr(8'h01, 8'h01);
        wait_n(1);   chk("R4 bright -> daylight", 100);
        amb_bright = 1'b0; amb_dusk = 1'b1;
        wait_n(2);   chk("R4 dusk -> office", 70);
        amb_dusk = 1'b0;
        wait_n(2);   chk("R4 none -> dark", 50);
        wr(8'h04, 8'h00);
        wait_n(2);   chk("R4 manual field ignored", 50);
    endtask

    task automatic t_restart;
        wr(8'h06, 8'h00);
        wr(8'h05, 8'h00);
        amb_bright = 1'b1;
        wait_n(51);  chk("R10 first leg k=50", 75);
        amb_bright = 1'b0;
        wait_n(41);  chk("R10 restarted leg k=40", 66);
        wait_n(70);  chk("R10 restarted leg done", 50);
    endtask

    initial begin
        wait_n(2);
        rst_n = 1'b1;
        t_reset();
        t_linear_up();
        t_square_down();
        t_cubic_up();
        t_override_dim();
        t_manual_levels();
        t_auto();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: led_code=%0d expected run to end", led_code);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule